// File: doc/BRIEF.md
# Three-Tap Window Fetcher with Per-Position Queues

This block supplies a three-tap streaming datapath with one operand window per iteration. For iteration i it reads array elements i, i+1 and i+2 from a word-addressed memory read port. It fetches the whole window again on every iteration, so neighbouring windows share no data. Each returned word goes into the queue for its window position. A window leaves the block once all three queues hold an entry and the consumer is ready.

A one-cycle `start` pulse captures the iteration count and the base address and begins fetching at iteration 0. Memory responses come back in request order, with any latency. Before a request is issued, space for it is reserved in its target queue, so a response never finds its queue full. When the consumer stalls, requests stop as soon as the reservations are used up. `done` rises after the last window has been accepted.

Back-pressure rules: the memory request side is valid/ready. While `mem_req_valid` is high and not accepted, it stays high and the address does not change. The response side has no ready signal, because space is reserved in advance. The window output is valid/ready. While `win_valid` is high and `win_ready` is low, the window stays valid and unchanged. If the next window is not complete, `win_valid` is low for that cycle: the block sends a bubble, never stale data.

Top module: `window_fetcher`

## Requirements
- R1: For iteration i (counted from 0) the block requests addresses base+i, base+i+1 and base+i+2, in that order, with iterations ascending. The addresses wrap modulo 2^ADDR_W. A run of N iterations issues exactly 3*N requests, for example 300 for N=100.
- R2: The j-th memory response of a run (counted from 0) is stored in queue j mod 3. Window slot k sits at `win_data[k*DATA_W +: DATA_W]` and carries element i+k.
- R3: A request to queue k is issued only while the entries stored in queue k plus its requests still in flight total less than DEPTH. A response therefore never arrives at a full queue.
- R4: Windows are delivered in iteration order, with no window repeated or skipped.
- R5: `win_valid` is high exactly when all three queues are non-empty. While it is high and `win_ready` is low, `win_valid` and `win_data` hold.
- R6: When a window is accepted (`win_valid` and `win_ready` both high), one entry is removed from each of the three queues in the same cycle.
- R7: `done` is a sticky flag:
  - It goes high the cycle after the N-th window is accepted.
  - A start with N=0 sets it on the next cycle and issues no requests.
  - A start that is accepted clears it.
  - A start while a run is in progress is ignored.
  - While `done` is high, no requests are issued.
- R8: A synchronous active-high reset does the following: it empties all queues, drops all reservations and stops address generation. It also forces `mem_req_valid`, `win_valid` and `done` low in the following cycle.
- R9: When the consumer holds `win_ready` low, at most DEPTH windows are requested (3*DEPTH reads). After that, `mem_req_valid` stays low until a window is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that starts a run; ignored while a run is in progress |
| iter_count | input | CNT_W | Number of iterations N, captured at start |
| base_addr | input | ADDR_W | Word address of element 0, captured at start |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W | Word address of the request |
| mem_rsp_valid | input | 1 | Read data returned, in request order |
| mem_rsp_data | input | DATA_W | Returned word |
| win_valid | output | 1 | Complete window available |
| win_ready | input | 1 | Consumer accepts the window |
| win_data | output | 3*DATA_W | Window; slot k at bits [k*DATA_W +: DATA_W] |
| done | output | 1 | All N windows have been accepted |

## Verification
The bound assertions check four behaviours on every cycle:
- no response ever lands in a full queue;
- a pending request holds its address and a stalled window holds its data;
- `done` and request activity never overlap;
- the quiet state after reset.

Other behaviours can only be shown by the bench's scenarios:
- the address order and the total read count;
- the routing of responses to queues and the window contents;
- the exact point where requests stop under a stalled consumer;
- ignoring a start during a run, the zero-iteration case, and a reset in the middle of a run.

The bench drives random memory latencies and random handshakes on both sides.

// File: rtl/wf_pkg.sv
package wf_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_t;

  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/wf_lane_fifo.sv
module wf_lane_fifo #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] din,
  input  logic              pop,
  output logic [DATA_W-1:0] dout,
  output logic              empty,
  output logic              full
);
  localparam int unsigned PW = wf_pkg::idx_w(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] store [DEPTH];
  logic [PW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     fill;

  assign empty = (fill == '0);
  assign full  = (fill == CW'(DEPTH));
  assign dout  = store[rd_ptr];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) store[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end
endmodule

// File: rtl/wf_addr_gen.sv
module wf_addr_gen #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned LANES  = 3
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                start,
  input  logic [CNT_W-1:0]                    iter_count,
  input  logic [ADDR_W-1:0]                   base_addr,
  input  logic [LANES-1:0]                    lane_room,
  input  logic                                req_ready,
  input  logic                                win_fire,
  output logic                                req_valid,
  output logic [ADDR_W-1:0]                   req_addr,
  output logic [wf_pkg::idx_w(LANES)-1:0]     req_lane,
  output logic                                done
);
  import wf_pkg::*;
  localparam int unsigned LW = idx_w(LANES);

  run_state_t        state;
  logic              issuing;
  logic [CNT_W-1:0]  total, iter, accepted;
  logic [LW-1:0]     lane;
  logic [ADDR_W-1:0] base_q;
  logic              room_sel;
  logic              req_fire;

  always_comb begin
    room_sel = 1'b0;
    for (int k = 0; k < LANES; k++) begin
      if (lane == LW'(k)) room_sel = lane_room[k];
    end
  end

  assign req_valid = issuing && room_sel;
  assign req_fire  = req_valid && req_ready;
  assign req_lane  = lane;
  assign req_addr  = base_q + ADDR_W'(iter) + ADDR_W'(lane);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      issuing  <= 1'b0;
      done     <= 1'b0;
      total    <= '0;
      iter     <= '0;
      accepted <= '0;
      lane     <= '0;
      base_q   <= '0;
    end else if (state == ST_IDLE) begin
      if (start) begin
        total    <= iter_count;
        iter     <= '0;
        accepted <= '0;
        lane     <= '0;
        base_q   <= base_addr;
        if (iter_count == '0) begin
          done <= 1'b1;
        end else begin
          done    <= 1'b0;
          state   <= ST_RUN;
          issuing <= 1'b1;
        end
      end
    end else begin
      if (req_fire) begin
        if (lane == LW'(LANES - 1)) begin
          lane <= '0;
          iter <= iter + 1'b1;
          if (iter == total - 1'b1) issuing <= 1'b0;
        end else begin
          lane <= lane + 1'b1;
        end
      end
      if (win_fire) begin
        accepted <= accepted + 1'b1;
        if (accepted == total - 1'b1) begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/window_fetcher.sv
module window_fetcher #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned LANES  = 3,
  parameter int unsigned DEPTH  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [CNT_W-1:0]        iter_count,
  input  logic [ADDR_W-1:0]       base_addr,
  output logic                    mem_req_valid,
  input  logic                    mem_req_ready,
  output logic [ADDR_W-1:0]       mem_req_addr,
  input  logic                    mem_rsp_valid,
  input  logic [DATA_W-1:0]       mem_rsp_data,
  output logic                    win_valid,
  input  logic                    win_ready,
  output logic [LANES*DATA_W-1:0] win_data,
  output logic                    done
);
  localparam int unsigned LW = wf_pkg::idx_w(LANES);
  localparam int unsigned RW = $clog2(DEPTH + 1);

  logic [LANES-1:0] lane_room, lane_empty, lane_full;
  logic [LW-1:0]    req_lane, rsp_lane;
  logic             win_fire, req_fire, rsp_lane_full;

  assign win_valid = ~|lane_empty;
  assign win_fire  = win_valid && win_ready;
  assign req_fire  = mem_req_valid && mem_req_ready;

  wf_addr_gen #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .LANES(LANES)) u_agen (
    .clk(clk), .rst(rst), .start(start), .iter_count(iter_count),
    .base_addr(base_addr), .lane_room(lane_room), .req_ready(mem_req_ready),
    .win_fire(win_fire), .req_valid(mem_req_valid), .req_addr(mem_req_addr),
    .req_lane(req_lane), .done(done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_lane <= '0;
    end else if (mem_rsp_valid) begin
      rsp_lane <= (rsp_lane == LW'(LANES - 1)) ? '0 : rsp_lane + 1'b1;
    end
  end

  always_comb begin
    rsp_lane_full = 1'b0;
    for (int k = 0; k < LANES; k++) begin
      if (rsp_lane == LW'(k)) rsp_lane_full = lane_full[k];
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [RW-1:0]     reserved;
    logic              take;
    logic [DATA_W-1:0] head;

    assign take         = req_fire && (req_lane == LW'(k));
    assign lane_room[k] = (reserved < RW'(DEPTH));

    always_ff @(posedge clk) begin
      if (rst) begin
        reserved <= '0;
      end else begin
        case ({take, win_fire})
          2'b10:   reserved <= reserved + 1'b1;
          2'b01:   reserved <= reserved - 1'b1;
          default: reserved <= reserved;
        endcase
      end
    end

    wf_lane_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst(rst),
      .push(mem_rsp_valid && (rsp_lane == LW'(k))), .din(mem_rsp_data),
      .pop(win_fire), .dout(head), .empty(lane_empty[k]), .full(lane_full[k])
    );

    assign win_data[k*DATA_W +: DATA_W] = head;
  end
endmodule

// File: rtl/wf_checker.sv
module wf_checker #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned LANES  = 3
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    mem_req_valid,
  input logic                    mem_req_ready,
  input logic [ADDR_W-1:0]       mem_req_addr,
  input logic                    mem_rsp_valid,
  input logic                    rsp_lane_full,
  input logic                    win_valid,
  input logic                    win_ready,
  input logic [LANES*DATA_W-1:0] win_data,
  input logic                    done
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    mem_rsp_valid |-> !rsp_lane_full); // R3

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R1

  AST_WIN_HOLD: assert property (@(posedge clk) disable iff (rst)
    win_valid && !win_ready |=> win_valid && $stable(win_data)); // R5

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
    done |-> !mem_req_valid); // R7

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> !mem_req_valid && !win_valid && !done); // R8
endmodule

bind window_fetcher wf_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
  .clk(clk), .rst(rst), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid), .rsp_lane_full(rsp_lane_full),
  .win_valid(win_valid), .win_ready(win_ready), .win_data(win_data), .done(done)
);

// File: tb/window_fetcher_test.sv
`timescale 1ns/1ps
module window_fetcher_test;
  localparam int DW = 16, AW = 16, CW = 16, NL = 3, DEPTH = 4;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [CW-1:0] iter_count = '0;
  logic [AW-1:0] base_addr = '0;
  logic mem_req_valid, mem_req_ready = 1'b0;
  logic [AW-1:0] mem_req_addr;
  logic mem_rsp_valid = 1'b0;
  logic [DW-1:0] mem_rsp_data = '0;
  logic win_valid, win_ready = 1'b0, done;
  logic [NL*DW-1:0] win_data;

  window_fetcher #(.DATA_W(DW), .ADDR_W(AW), .CNT_W(CW), .LANES(NL), .DEPTH(DEPTH)) uut (.*);

  always #4 clk = ~clk;

  int tests = 0, fails = 0, cyc = 0;
  int seed = 7;
  int req_mode = 0, win_mode = 0, lat_mode = 0;
  logic start_req = 0, rst_req = 0;
  // reference model state
  int mq[$], mt[$], lq0[$], lq1[$], lq2[$];
  int m_res[NL];
  int m_n = 0, m_base = 0, m_issued = 0, m_acc = 0, m_rl = 0;
  bit m_busy = 0, m_done = 0;
  int nreq = 0, nwin = 0;

  function automatic int rnd();
    seed = seed * 1103515245 + 12345;
    return (seed >>> 16) & 32'h7fff;
  endfunction

  function automatic int mem_f(input int a);
    return (a * 37 + 11) & 16'hffff;
  endfunction

  function automatic logic pick(input int mode);
    case (mode)
      0: return 1'b1;
      1: return 1'(rnd() % 2);
      2: return 1'b0;
      default: return (rnd() % 4) != 0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic model_clear();
    mq.delete(); mt.delete(); lq0.delete(); lq1.delete(); lq2.delete();
    foreach (m_res[k]) m_res[k] = 0;
    m_issued = 0; m_acc = 0; m_rl = 0; m_busy = 0; m_done = 0;
  endtask

  task automatic step();
    bit rsp_now, exp_rv, exp_wv;
    int lane, t, ea;
    @(negedge clk);
    cyc++;
    rsp_now = (mq.size() > 0) && (mt[0] <= cyc);
    mem_rsp_valid = rsp_now;
    mem_rsp_data  = rsp_now ? DW'(mem_f(mq[0])) : '0;
    mem_req_ready = pick(req_mode);
    win_ready     = pick(win_mode);
    start = start_req; start_req = 0;
    rst   = rst_req;   rst_req = 0;
    #1;
    // per-cycle comparison against the model
    exp_rv = m_busy && (m_issued < 3 * m_n) && (m_res[m_issued % 3] < DEPTH);
    chk(mem_req_valid == exp_rv, "R3 R9 req_valid", int'(mem_req_valid), int'(exp_rv));
    if (mem_req_valid && exp_rv) begin
      ea = (m_base + m_issued / 3 + m_issued % 3) & 16'hffff;
      chk(int'(mem_req_addr) == ea, "R1 request address", int'(mem_req_addr), ea);
    end
    exp_wv = (lq0.size() > 0) && (lq1.size() > 0) && (lq2.size() > 0);
    chk(win_valid == exp_wv, "R5 R6 win_valid", int'(win_valid), int'(exp_wv));
    chk(done == m_done, "R7 done", int'(done), int'(m_done));
    if (win_valid && win_ready && exp_wv) begin
      for (int k = 0; k < NL; k++) begin
        ea = mem_f((m_base + m_acc + k) & 16'hffff);
        chk(int'(win_data[k*DW +: DW]) == ea, "R2 R4 window slot", int'(win_data[k*DW +: DW]), ea);
      end
    end
    if (rst) begin
      model_clear();
      return;
    end
    // model updates for the coming edge
    if (start && !m_busy) begin
      m_n = int'(iter_count); m_base = int'(base_addr);
      m_issued = 0; m_acc = 0;
      if (m_n == 0) m_done = 1; else begin m_busy = 1; m_done = 0; end
    end
    if (mem_req_valid && mem_req_ready) begin
      lane = m_issued % 3;
      mq.push_back(int'(mem_req_addr));
      t = cyc + ((lat_mode != 0) ? 1 + rnd() % 5 : 1);
      if (mt.size() > 0 && mt[$] > t) t = mt[$];
      mt.push_back(t);
      m_res[lane]++; m_issued++; nreq++;
    end
    if (rsp_now) begin
      case (m_rl)
        0: lq0.push_back(mq[0]);
        1: lq1.push_back(mq[0]);
        default: lq2.push_back(mq[0]);
      endcase
      void'(mq.pop_front()); void'(mt.pop_front());
      m_rl = (m_rl + 1) % 3;
    end
    if (win_valid && win_ready) begin
      if (lq0.size() > 0) void'(lq0.pop_front());
      if (lq1.size() > 0) void'(lq1.pop_front());
      if (lq2.size() > 0) void'(lq2.pop_front());
      foreach (m_res[k]) m_res[k]--;
      m_acc++; nwin++;
      if (m_acc == m_n) begin m_busy = 0; m_done = 1; end
    end
  endtask

  task automatic go(input int n, input int b);
    iter_count = CW'(n); base_addr = AW'(b);
    nreq = 0; nwin = 0;
    start_req = 1;
    step();
  endtask

  task automatic finish_run();
    while (m_busy) step();
    step();
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    summary();
  end

  initial begin
    // R8: reset state
    repeat (3) begin rst_req = 1; step(); end
    repeat (3) step();
    chk(!mem_req_valid && !win_valid && !done, "R8 reset outputs",
        int'({mem_req_valid, win_valid, done}), 0);

    // R1: long run, fast memory, free-flowing consumer
    req_mode = 0; win_mode = 0; lat_mode = 0;
    go(100, 0); finish_run();
    chk(nreq == 300, "R1 total reads", nreq, 300);
    chk(nwin == 100, "R4 windows delivered", nwin, 100);

    // random latencies and handshakes on both sides
    req_mode = 1; win_mode = 1; lat_mode = 1;
    go(10, 500); finish_run();
    chk(nreq == 30, "R1 total reads random", nreq, 30);
    req_mode = 3; win_mode = 3;
    go(25, 1234); finish_run();
    chk(nwin == 25, "R4 windows random", nwin, 25);

    // R9: stalled consumer limits outstanding reads
    req_mode = 0; win_mode = 2; lat_mode = 0;
    go(20, 100);
    repeat (60) step();
    chk(nreq == 3 * DEPTH, "R9 reads while stalled", nreq, 3 * DEPTH);
    chk(win_valid == 1'b1, "R5 window held while stalled", int'(win_valid), 1);
    win_mode = 0; finish_run();
    chk(nreq == 60, "R9 reads after release", nreq, 60);

    // R7: start during a run is ignored
    win_mode = 3; lat_mode = 1;
    go(15, 300);
    repeat (5) step();
    iter_count = 3; base_addr = 999; start_req = 1; step();
    finish_run();
    chk(nwin == 15, "R7 start while busy ignored", nwin, 15);

    // R7: zero iterations
    go(0, 5);
    step();
    chk(done == 1'b1 && nreq == 0, "R7 zero iterations", nreq, 0);

    // R1: address wrap near the top of the space
    win_mode = 0; lat_mode = 0;
    go(4, 16'hfffe); finish_run();
    chk(nreq == 12, "R1 wrap reads", nreq, 12);

    // R8: reset in the middle of a run, then a fresh run
    lat_mode = 1; win_mode = 1;
    go(30, 40);
    repeat (20) step();
    rst_req = 1; step();
    step();
    chk(!mem_req_valid && !win_valid && !done, "R8 reset mid-run",
        int'({mem_req_valid, win_valid, done}), 0);
    repeat (6) step();
    chk(!win_valid, "R8 stale responses dropped", int'(win_valid), 0);
    go(8, 7); finish_run();
    chk(nwin == 8, "R6 fresh run after reset", nwin, 8);

    summary();
  end
endmodule